// File: doc/BRIEF.md
# Single-Channel Register-Programmed DMA Engine

This block copies a stream of data items from a read master port to a write master port. Software programs it through a small word-addressed register window. The window holds a source address, a destination address, a remaining byte count, a control byte and a status byte. When the run bit is set, the count is non-zero and the completion flag is clear, the engine begins a transaction. It alternates between fetching one item and storing that item. Each item is a byte, a halfword or a word. After every accepted access the matching address advances by the item size. After every store the count falls by the item size.

Three independently enabled conditions can end a transaction:

- the count running out;
- an end-of-packet marker that the read-side slave returns with a data item;
- an end-of-packet marker that the write-side slave returns when it accepts a store.

Completion sets a sticky flag. That flag drives the interrupt line when interrupts are enabled. Software clears the flag by writing any value to the status register. A separate sticky flag records that the count reached zero.

The sequencer has three states:

- `ST_IDLE`: no transaction is running.
- `ST_FETCH`: the holding register is empty and a read is requested.
- `ST_STORE`: the holding register is full and a write is requested.

It has four transitions:

- `ST_IDLE`→`ST_FETCH` on start.
- `ST_FETCH`→`ST_STORE` when a read is accepted.
- `ST_STORE`→`ST_FETCH` when a write is accepted and no end condition holds.
- `ST_STORE`→`ST_IDLE` when a write is accepted and an end condition holds. This transition also sets the completion flag.

Top module: `dmac_top`

## Requirements
- R1: After reset every register reads 0, `rd_req`, `wr_req` and `irq` are low.
- R2: The length register counts bytes. Each accepted write lowers it by the item size (1, 2 or 4), saturating at 0 rather than wrapping. When an accepted write brings it to 0, status bit 4 (count-zero) is set.
- R3: The item size comes from control bits 0 (byte), 1 (halfword) and 2 (word). If several are set, the largest wins; if none is set, a byte is used. The size is latched at start. It is driven on `xfer_size` as 0 = byte, 1 = halfword, 2 = word.
- R4: A transaction starts only when control bit 3 (run) is 1, the length is non-zero and status bit 0 (DONE) is 0. While run is 0, no request is raised. Clearing run during a transaction pauses it; BUSY stays set and the transaction resumes when run is set again.
- R5: With control bit 7 set, the transaction ends on the write that brings the length to 0. With bit 7 clear, transfers continue past a zero length. Ending sets status bit 0 (DONE) and clears status bit 1 (BUSY).
- R6: `irq` is high exactly when control bit 4 is 1 and DONE is 1. Any write to the status register clears DONE, bits 2, 3 and 4, and therefore `irq`.
- R7: The read and write addresses each advance by the item size after every accepted read or write. Each write carries the data of the matching read, in order.
- R8: A single holding entry sits between the two sides. A read is requested only while the entry is empty, and a write only while it is full. `rd_req` and `wr_req` are never high together.
- R9: While BUSY is set, writes to the address and length registers are ignored. Writes to the control register are always taken.
- R10: With control bit 5 set, a read accepted with `rd_eop` high sets status bit 2. That item is still written, and then the transaction ends. With bit 5 clear, `rd_eop` has no effect.
- R11: With control bit 6 set, a write accepted with `wr_eop` high sets status bit 3 and ends the transaction. With bit 6 clear, `wr_eop` has no effect.
- R12: The register offsets are status 0, read address 1, write address 2, length 3 and control 6. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 3 | Register word offset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational from `csr_addr`) |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_data | input | 32 | Read data, valid with `rd_ack` |
| rd_ack | input | 1 | Read accepted this cycle |
| rd_eop | input | 1 | Read-side end-of-packet, sampled with `rd_ack` |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted this cycle |
| wr_eop | input | 1 | Write-side end-of-packet, sampled with `wr_ack` |
| xfer_size | output | 2 | Item size of the current transaction |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with AW = 16 and LW = 10. With these values, addresses can be compared directly against a 16-bit address-derived data pattern, and length values such as 100 still fit the register.

The narrow length keeps the saturating decrement within reach. A byte transaction ended by a read-side marker runs the count past zero, so the clamp at 0 is exercised.

A switchable acknowledge lets the bench hold a transaction busy. While it is held, the bench checks that edits to the protected registers are ignored and that clearing the run bit pauses the engine.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } dmac_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } dmac_size_e;

    localparam int CSR_AW = 3;
    localparam int CSR_DW = 32;
    localparam int CTL_W  = 8;

    localparam logic [CSR_AW-1:0] OFF_STAT  = 3'd0;
    localparam logic [CSR_AW-1:0] OFF_RADDR = 3'd1;
    localparam logic [CSR_AW-1:0] OFF_WADDR = 3'd2;
    localparam logic [CSR_AW-1:0] OFF_LEN   = 3'd3;
    localparam logic [CSR_AW-1:0] OFF_CTRL  = 3'd6;

    localparam int CB_BYTE = 0;
    localparam int CB_HALF = 1;
    localparam int CB_WORD = 2;
    localparam int CB_RUN  = 3;
    localparam int CB_IEN  = 4;
    localparam int CB_REND = 5;
    localparam int CB_WEND = 6;
    localparam int CB_LEND = 7;

    function automatic dmac_size_e size_pick(input logic [2:0] sel);
        if (sel[CB_WORD])      return SZ_WORD;
        else if (sel[CB_HALF]) return SZ_HALF;
        else                   return SZ_BYTE;
    endfunction

    function automatic logic [2:0] size_bytes(input dmac_size_e sz);
        unique case (sz)
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/dmac_hold.sv
module dmac_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          eop_in,
    output logic [DW-1:0] dout,
    output logic          eop_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            eop_q <= 1'b0;
        end else if (load) begin
            dout  <= din;
            eop_q <= eop_in;
        end
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_wr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic              busy,
    input  logic              rd_fire,
    input  logic              wr_fire,
    input  logic [2:0]        step,
    input  logic              fin,
    input  logic              reop_set,
    input  logic              weop_set,
    output logic [AW-1:0]     raddr_q,
    output logic [AW-1:0]     waddr_q,
    output logic [LW-1:0]     len_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              done_q,
    output logic              irq
);
    logic reop_q, weop_q, lenz_q;
    logic len_le_step;
    logic unused_wdata;

    assign len_le_step  = (len_q <= LW'(step));
    assign unused_wdata = ^csr_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raddr_q <= '0;
            waddr_q <= '0;
            len_q   <= '0;
            ctl_q   <= '0;
            done_q  <= 1'b0;
            reop_q  <= 1'b0;
            weop_q  <= 1'b0;
            lenz_q  <= 1'b0;
        end else begin
            if (csr_wr) begin
                case (csr_addr)
                    OFF_STAT: begin
                        done_q <= 1'b0;
                        reop_q <= 1'b0;
                        weop_q <= 1'b0;
                        lenz_q <= 1'b0;
                    end
                    OFF_RADDR: if (!busy) raddr_q <= csr_wdata[AW-1:0];
                    OFF_WADDR: if (!busy) waddr_q <= csr_wdata[AW-1:0];
                    OFF_LEN:   if (!busy) len_q   <= csr_wdata[LW-1:0];
                    OFF_CTRL:  ctl_q <= csr_wdata[CTL_W-1:0];
                    default: ;
                endcase
            end
            if (rd_fire)
                raddr_q <= raddr_q + AW'(step);
            if (wr_fire) begin
                waddr_q <= waddr_q + AW'(step);
                len_q   <= len_le_step ? '0 : len_q - LW'(step);
                if (len_le_step)
                    lenz_q <= 1'b1;
            end
            if (reop_set) reop_q <= 1'b1;
            if (weop_set) weop_q <= 1'b1;
            if (fin)      done_q <= 1'b1;
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFF_STAT:  csr_rdata = {27'd0, lenz_q, weop_q, reop_q, busy, done_q};
            OFF_RADDR: csr_rdata = CSR_DW'(raddr_q);
            OFF_WADDR: csr_rdata = CSR_DW'(waddr_q);
            OFF_LEN:   csr_rdata = CSR_DW'(len_q);
            OFF_CTRL:  csr_rdata = CSR_DW'(ctl_q);
            default:   csr_rdata = '0;
        endcase
    end

    assign irq = ctl_q[CB_IEN] & done_q;
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl,
    input  logic [LW-1:0]    len_q,
    input  logic             done,
    input  logic             rd_ack,
    input  logic             rd_eop,
    input  logic             wr_ack,
    input  logic             wr_eop,
    input  logic             hold_eop,
    output logic             rd_req,
    output logic             wr_req,
    output dmac_size_e       xfer_size,
    output logic [2:0]       step,
    output logic             busy,
    output logic             rd_fire,
    output logic             wr_fire,
    output logic             cap_eop,
    output logic             fin,
    output logic             reop_set,
    output logic             weop_set
);
    dmac_state_e state_q, state_d;
    dmac_size_e  size_q;
    logic        start, end_now, run;

    assign run   = ctl[CB_RUN];
    assign start = (state_q == ST_IDLE) && run && (len_q != '0) && !done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= SZ_BYTE;
        end else begin
            state_q <= state_d;
            if (start)
                size_q <= size_pick(ctl[2:0]);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)   state_d = ST_FETCH;
            ST_FETCH: if (rd_fire) state_d = ST_STORE;
            ST_STORE: if (wr_fire) state_d = end_now ? ST_IDLE : ST_FETCH;
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req   = (state_q == ST_FETCH) && run;
        wr_req   = (state_q == ST_STORE) && run;
        rd_fire  = rd_req && rd_ack;
        wr_fire  = wr_req && wr_ack;
        step     = size_bytes(size_q);
        end_now  = hold_eop
                 || (wr_eop && ctl[CB_WEND])
                 || (ctl[CB_LEND] && (len_q <= LW'(step)));
        fin      = wr_fire && end_now;
        cap_eop  = rd_eop && ctl[CB_REND];
        reop_set = rd_fire && cap_eop;
        weop_set = wr_fire && wr_eop && ctl[CB_WEND];
        busy     = (state_q != ST_IDLE);
    end

    assign xfer_size = size_q;
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        csr_addr,
    input  logic              csr_wr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic [31:0]       rd_data,
    input  logic              rd_ack,
    input  logic              rd_eop,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    input  logic              wr_eop,
    output logic [1:0]        xfer_size,
    output logic              irq
);
    logic [LW-1:0]    len_q;
    logic [CTL_W-1:0] ctl_q;
    logic             st_done, busy, rd_fire, wr_fire, fin;
    logic             reop_set, weop_set, cap_eop, hold_eop;
    logic [2:0]       step;
    logic             ctl_go;
    dmac_size_e       size_e;

    assign ctl_go    = ctl_q[CB_RUN];
    assign xfer_size = size_e;

    dmac_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .busy(busy), .rd_fire(rd_fire), .wr_fire(wr_fire), .step(step),
        .fin(fin), .reop_set(reop_set), .weop_set(weop_set),
        .raddr_q(rd_addr), .waddr_q(wr_addr), .len_q(len_q),
        .ctl_q(ctl_q), .done_q(st_done), .irq(irq)
    );

    dmac_seq #(.LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .len_q(len_q), .done(st_done),
        .rd_ack(rd_ack), .rd_eop(rd_eop), .wr_ack(wr_ack), .wr_eop(wr_eop),
        .hold_eop(hold_eop), .rd_req(rd_req), .wr_req(wr_req),
        .xfer_size(size_e), .step(step), .busy(busy),
        .rd_fire(rd_fire), .wr_fire(wr_fire), .cap_eop(cap_eop), .fin(fin),
        .reop_set(reop_set), .weop_set(weop_set)
    );

    dmac_hold #(.DW(32)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(rd_fire), .din(rd_data),
        .eop_in(cap_eop), .dout(wr_data), .eop_q(hold_eop)
    );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr,
    input logic          wr_req,
    input logic          wr_ack,
    input logic          irq,
    input logic          go,
    input logic          busy,
    input logic          done,
    input logic [LW-1:0] len,
    input logic [2:0]    step
);
    assert_req_needs_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> go);

    assert_single_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    assert_raddr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> (rd_addr == $past(rd_addr) + AW'($past(step))));

    assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(wr_req && wr_ack)) |=> (len == $past(len)));

    assert_len_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && (len <= LW'(step))) |=> (len == '0));

    assert_irq_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_done_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
endmodule

bind dmac_top dmac_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_addr(rd_addr), .wr_req(wr_req), .wr_ack(wr_ack), .irq(irq),
    .go(ctl_go), .busy(busy), .done(st_done), .len(len_q), .step(step)
);

// File: tb/tb_dmac_top.sv
`timescale 1ns/1ps
module tb_dmac_top;
    localparam int AW = 16;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    csr_addr = '0;
    logic          csr_wr = 1'b0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          rd_req, wr_req, rd_ack, wr_ack, rd_eop, wr_eop, irq;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0]   rd_data, wr_data;
    logic [1:0]    xfer_size;

    logic          ack_en = 1'b1;
    logic [15:0]   eop_ra = 16'hFFFF;
    logic [15:0]   eop_wa = 16'hFFFF;
    int            n_chk = 0;
    int            n_fail = 0;
    int            req_seen = 0;

    typedef struct packed {
        logic [15:0] a;
        logic [31:0] d;
        logic [1:0]  s;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    function automatic logic [31:0] mem(input logic [15:0] a);
        return {~a, a};
    endfunction

    assign rd_data = mem(rd_addr);
    assign rd_ack  = rd_req & ack_en;
    assign wr_ack  = wr_req & ack_en;
    assign rd_eop  = rd_req & (rd_addr == eop_ra);
    assign wr_eop  = wr_req & (wr_addr == eop_wa);

    dmac_top #(.AW(AW), .LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack),
        .rd_eop(rd_eop), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_eop(wr_eop), .xfer_size(xfer_size), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic reg_is(input logic [2:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        csr_read(a, v);
        check(v == e, tag, v, e);
    endtask

    // driver: queue the writes a transaction is expected to produce
    task automatic push_run(input logic [15:0] ra, input logic [15:0] wa,
                            input int n, input logic [1:0] sz);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.a = wa + 16'(i << sz);
            it.d = mem(ra + 16'(i << sz));
            it.s = sz;
            exp_q.push_back(it);
        end
    endtask

    task automatic setup(input logic [15:0] ra, input logic [15:0] wa,
                         input logic [31:0] len);
        csr_write(3'd6, 32'h0);
        csr_write(3'd0, 32'h0);
        csr_write(3'd1, {16'd0, ra});
        csr_write(3'd2, {16'd0, wa});
        csr_write(3'd3, len);
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 600; i++) begin
            csr_read(3'd0, v);
            if (v[0]) break;
        end
        check(v[0] == 1'b1, {tag, " done"}, v, 32'h1);
        check(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
    endtask

    // monitor: compare every accepted write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (rd_req || wr_req)) req_seen++;
        if (rst_n && wr_req && wr_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected write", {16'd0, wr_addr}, 32'hFFFF);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(wr_addr == it.a, "R7 write address", {16'd0, wr_addr}, {16'd0, it.a});
                check(wr_data == it.d, "R7 write data", wr_data, it.d);
                check(xfer_size == it.s, "R3 item size", {30'd0, xfer_size}, {30'd0, it.s});
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int seen;
        logic [31:0] v;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check({rd_req, wr_req, irq} == 3'b000, "R1 outputs idle", {29'd0, rd_req, wr_req, irq}, 0);
        reg_is(3'd0, 32'h0, "R1 status");
        reg_is(3'd3, 32'h0, "R1 length");
        reg_is(3'd6, 32'h0, "R1 control");

        // R2/R5/R6 word transfer ended by count, interrupt enabled
        setup(16'h0100, 16'h0200, 16);
        push_run(16'h0100, 16'h0200, 4, 2'd2);
        csr_write(3'd6, 32'h9C);
        wait_done("R5 word run");
        reg_is(3'd0, 32'h11, "R5 status done+count-zero");
        check(irq == 1'b1, "R6 irq raised", {31'd0, irq}, 1);
        reg_is(3'd3, 32'h0, "R2 length zero");
        reg_is(3'd1, 32'h0110, "R7 read address advanced");
        reg_is(3'd2, 32'h0210, "R7 write address advanced");
        csr_write(3'd0, 32'h0);
        reg_is(3'd0, 32'h0, "R6 status cleared");
        check(irq == 1'b0, "R6 irq cleared", {31'd0, irq}, 0);

        // R3 halfword, interrupts off
        setup(16'h0300, 16'h0400, 6);
        push_run(16'h0300, 16'h0400, 3, 2'd1);
        csr_write(3'd6, 32'h8A);
        wait_done("R3 halfword run");
        reg_is(3'd0, 32'h11, "R3 halfword status");
        check(irq == 1'b0, "R6 irq masked", {31'd0, irq}, 0);

        // R3 priority: all size bits set selects word
        setup(16'h0500, 16'h0600, 8);
        push_run(16'h0500, 16'h0600, 2, 2'd2);
        csr_write(3'd6, 32'h8F);
        wait_done("R3 size priority");

        // R10 read-side marker, count end off, length saturates
        setup(16'h0700, 16'h0800, 3);
        eop_ra = 16'h0704;
        push_run(16'h0700, 16'h0800, 5, 2'd0);
        csr_write(3'd6, 32'h29);
        wait_done("R10 read eop");
        reg_is(3'd0, 32'h15, "R10 status reop");
        reg_is(3'd3, 32'h0, "R2 saturated at zero");
        eop_ra = 16'hFFFF;

        // R11 write-side marker before count runs out
        setup(16'h0900, 16'h0A00, 40);
        eop_wa = 16'h0A08;
        push_run(16'h0900, 16'h0A00, 3, 2'd2);
        csr_write(3'd6, 32'hCC);
        wait_done("R11 write eop");
        reg_is(3'd0, 32'h09, "R11 status weop");
        reg_is(3'd3, 32'd28, "R2 length after partial");
        eop_wa = 16'hFFFF;

        // R4 no requests without run bit
        setup(16'h0B00, 16'h0C00, 8);
        csr_write(3'd6, 32'h84);
        seen = req_seen;
        repeat (20) @(negedge clk);
        check(req_seen == seen, "R4 idle without run", req_seen, seen);
        reg_is(3'd0, 32'h0, "R4 not busy");

        // R10 marker ignored when its enable is clear
        eop_ra = 16'h0B00;
        push_run(16'h0B00, 16'h0C00, 2, 2'd2);
        csr_write(3'd6, 32'h8C);
        wait_done("R10 marker ignored");
        reg_is(3'd0, 32'h11, "R10 no reop flag");
        eop_ra = 16'hFFFF;

        // R9 protected registers while busy, R4 pause
        setup(16'h0D00, 16'h0E00, 8);
        ack_en = 1'b0;
        csr_write(3'd6, 32'h8C);
        repeat (5) @(negedge clk);
        reg_is(3'd0, 32'h02, "R4 busy");
        csr_write(3'd3, 32'd100);
        csr_write(3'd1, 32'h1234);
        reg_is(3'd3, 32'd8, "R9 length write ignored");
        reg_is(3'd1, 32'h0D00, "R9 address write ignored");
        csr_write(3'd6, 32'h84);
        repeat (2) @(negedge clk);
        check(rd_req == 1'b0, "R4 paused no request", {31'd0, rd_req}, 0);
        reg_is(3'd0, 32'h02, "R4 still busy when paused");
        reg_is(3'd6, 32'h84, "R9 control taken while busy");
        push_run(16'h0D00, 16'h0E00, 2, 2'd2);
        csr_write(3'd6, 32'h8C);
        ack_en = 1'b1;
        wait_done("R4 resume");
        reg_is(3'd0, 32'h11, "R4 resume status");

        // R4 no restart while DONE is set
        csr_write(3'd3, 32'd4);
        seen = req_seen;
        repeat (10) @(negedge clk);
        check(req_seen == seen, "R4 done blocks start", req_seen, seen);
        reg_is(3'd3, 32'd4, "R9 length taken when idle");
        push_run(16'h0D08, 16'h0E08, 1, 2'd2);
        csr_write(3'd0, 32'h0);
        wait_done("R4 start after clear");

        // R12 offsets
        reg_is(3'd4, 32'h0, "R12 unmapped offset");
        reg_is(3'd6, 32'h8C, "R12 control offset");
        reg_is(3'd1, 32'h0D0C, "R12 read address offset");
        csr_read(3'd0, v);
        check(v == 32'h11, "R12 status offset", v, 32'h11);

        summary();
        $finish;
    end
endmodule